// File: doc/BRIEF.md
# Three-Channel UTOPIA Transmit Cell Sink

This block sits on the PHY side of a UTOPIA Level 1 transmit bus that serves three channels. The ATM-layer master drives one shared 8-bit data bus, one parity bit and one start-of-cell strobe, plus an enable line for each channel. The block answers with a cell-available flag for each channel. It collects 53-byte cells into a two-cell buffer per channel and checks odd parity on every stored byte. Finished cells are handed out, one byte per request, on a read port for each channel.

A mode bit, written through a one-bit configuration strobe, chooses between two throttling styles. In cell mode the available flag is a look-ahead: it tells the master whether another whole cell would fit, and it has no effect on a cell that is already in progress. In byte mode the flag qualifies every byte, and a byte is taken only when both enable and flag are high. Malformed traffic is discarded and reported on single-cycle error pulses. These cases are short cells, stray bytes, cells that arrive with no free slot, and cycles in which more than one enable is high. Everything runs on one free-running clock.

Top module: `utx_cell_sink`

## Requirements
- R1: The three channels share data, parity and start-of-cell but are otherwise independent: bytes for different channels may interleave cycle by cycle, and each channel assembles only the bytes that arrive with its own enable bit high.
- R2: In cell mode, `tx_clav[c]` is high when the number of stored cells plus one for a cell in progress is below the buffer depth. It is a register that reflects the channel state of the previous cycle. It is low while reset is held and high one clock after reset is released.
- R3: In byte mode, `tx_clav[c]` stays high while a cell is in progress on channel c. Otherwise it is high only when the buffer has a free slot. Like R2, it is updated one cycle after the state changes.
- R4: A byte is taken only on a clock where the channel's enable is high. In byte mode, `tx_clav[c]` must also be high. A low enable pauses a cell without aborting it.
- R5: A cell is 53 bytes, with `tx_soc` high only on its first byte. The bytes are read back in arrival order: header bytes 0 to 4, then payload bytes 5 to 52.
- R6: A start-of-cell that arrives during a cell discards the partial cell, pulses `cell_err[c]` for one cycle, and starts a new cell with that byte. A byte without start-of-cell outside a cell is dropped with the same pulse.
- R7: Parity is odd: the XOR of the eight data bits and `tx_par` must be 1. A stored byte that fails this check sets `par_err[c]`, which stays set until reset. The byte is still stored.
- R8: Each channel holds two cells. In cell mode, a start-of-cell with no free slot drops that byte and pulses `cell_err[c]`. In byte mode, the same byte with `tx_clav[c]` low is not taken and raises no error.
- R9: When more than one enable bit is high, `proto_err` pulses in the next cycle and the byte is ignored by every channel.
- R10: `cell_rdy[c]` is high while at least one whole cell is stored. `rd_en[c]` sampled high with `cell_rdy[c]` high returns the next byte in the following cycle with `rd_vld[c]`. `rd_last[c]` marks the 53rd byte, after which the slot is free. `rd_en[c]` has no effect while `cell_rdy[c]` is low.
- R11: The mode register is 0 for cell mode and 1 for byte mode. It is loaded from `cfg_mode` when `cfg_we` is high and resets to cell mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transmit clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads the mode register |
| cfg_mode | input | 1 | Mode value: 0 cell, 1 byte |
| tx_en | input | NUM_CH | Per-channel transfer enable from the master |
| tx_data | input | DW | Shared data byte |
| tx_par | input | 1 | Odd parity over tx_data |
| tx_soc | input | 1 | Shared start-of-cell strobe |
| tx_clav | output | NUM_CH | Per-channel cell-available flag |
| cell_rdy | output | NUM_CH | A complete cell is stored |
| rd_en | input | NUM_CH | Per-channel byte read request |
| rd_data | output | NUM_CH*DW | Read bytes, channel c in slice c*DW |
| rd_vld | output | NUM_CH | rd_data slice is valid |
| rd_last | output | NUM_CH | Byte is the last of its cell |
| cell_err | output | NUM_CH | One-cycle pulse for a discarded cell or byte |
| par_err | output | NUM_CH | Sticky parity error |
| proto_err | output | 1 | One-cycle pulse for multiple enables |

## Verification
The bench builds the block with its default values: three channels, 8-bit data, 53-byte cells and two cells per channel. Because the buffer holds only two cells, a channel can be filled after two transfers. That makes both the no-room start-of-cell case and the mid-cell drop of the available flag reachable within a few hundred cycles. With three channels, interleaved traffic on two of them can run while the third keeps its state, and a multi-enable byte can land in the middle of a live cell.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic {
    MODE_CELL = 1'b0,
    MODE_BYTE = 1'b1
  } utx_mode_e;

  localparam int unsigned UTX_DEF_CH    = 3;
  localparam int unsigned UTX_DEF_DW    = 8;
  localparam int unsigned UTX_DEF_CELL  = 53;
  localparam int unsigned UTX_DEF_SLOTS = 2;

endpackage

// File: rtl/utx_cell_ram.sv
module utx_cell_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 106,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/utx_chan_ctrl.sv
module utx_chan_ctrl
  import utx_pkg::*;
#(
  parameter int DW         = 8,
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  utx_mode_e     mode,
  input  logic          take,
  input  logic          soc,
  input  logic [DW-1:0] data,
  input  logic          par,
  input  logic          rd_en,
  output logic          clav,
  output logic          cell_rdy,
  output logic          cell_err,
  output logic          par_err,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  output logic          rd_last
);

  localparam int BC_W   = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1;
  localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int CNT_W  = $clog2(CELLS + 1);
  localparam int DEPTH  = CELLS * CELL_BYTES;
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [BC_W-1:0]   LAST_B  = BC_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_S  = SLOT_W'(CELLS - 1);
  localparam logic [CNT_W-1:0]  CELLS_C = CNT_W'(CELLS);

  function automatic logic [AW-1:0] addr_of(input logic [SLOT_W-1:0] s,
                                            input logic [BC_W-1:0]   b);
    return AW'(s) * AW'(CELL_BYTES) + AW'(b);
  endfunction

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (s == LAST_S) ? '0 : s + SLOT_W'(1);
  endfunction

  // write side state
  logic              in_cell_q, in_cell_d;
  logic [BC_W-1:0]   wbyte_q, wbyte_d;
  logic [SLOT_W-1:0] wslot_q, wslot_d;
  // read side state
  logic [BC_W-1:0]   rbyte_q, rbyte_d;
  logic [SLOT_W-1:0] rslot_q, rslot_d;
  logic [CNT_W-1:0]  stored_q, stored_d;
  // registered outputs
  logic clav_q, clav_d, err_q, err_d, perr_q, perr_d, vld_q, last_q;

  logic            accept, has_free, we, commit, rd_go, release_slot;
  logic [BC_W-1:0] wpos;

  assign has_free = stored_q < CELLS_C;
  assign accept   = take & ((mode == MODE_CELL) | clav_q);

  always_comb begin
    in_cell_d = in_cell_q;
    wbyte_d   = wbyte_q;
    wslot_d   = wslot_q;
    err_d     = 1'b0;
    we        = 1'b0;
    wpos      = wbyte_q;
    commit    = 1'b0;
    if (accept) begin
      if (soc) begin
        err_d = in_cell_q | ~has_free;
        if (has_free) begin
          we        = 1'b1;
          wpos      = '0;
          in_cell_d = 1'b1;
          wbyte_d   = BC_W'(1);
        end else begin
          in_cell_d = 1'b0;
          wbyte_d   = '0;
        end
      end else if (in_cell_q) begin
        we = 1'b1;
        if (wbyte_q == LAST_B) begin
          commit    = 1'b1;
          in_cell_d = 1'b0;
          wbyte_d   = '0;
          wslot_d   = next_slot(wslot_q);
        end else begin
          wbyte_d = wbyte_q + BC_W'(1);
        end
      end else begin
        err_d = 1'b1;
      end
    end
  end

  assign rd_go        = rd_en & (stored_q != '0);
  assign release_slot = rd_go & (rbyte_q == LAST_B);

  always_comb begin
    rbyte_d = rbyte_q;
    rslot_d = rslot_q;
    if (rd_go) begin
      if (release_slot) begin
        rbyte_d = '0;
        rslot_d = next_slot(rslot_q);
      end else begin
        rbyte_d = rbyte_q + BC_W'(1);
      end
    end
    stored_d = stored_q + CNT_W'(commit) - CNT_W'(release_slot);
  end

  always_comb begin
    if (mode == MODE_BYTE) begin
      clav_d = in_cell_q | has_free;
    end else begin
      clav_d = ({1'b0, stored_q} + (CNT_W+1)'(in_cell_q)) < (CNT_W+1)'(CELLS);
    end
    perr_d = perr_q | (we & ~(^{data, par}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cell_q <= 1'b0;
      wbyte_q   <= '0;
      wslot_q   <= '0;
      rbyte_q   <= '0;
      rslot_q   <= '0;
      stored_q  <= '0;
      clav_q    <= 1'b0;
      err_q     <= 1'b0;
      perr_q    <= 1'b0;
      vld_q     <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      in_cell_q <= in_cell_d;
      wbyte_q   <= wbyte_d;
      wslot_q   <= wslot_d;
      rbyte_q   <= rbyte_d;
      rslot_q   <= rslot_d;
      stored_q  <= stored_d;
      clav_q    <= clav_d;
      err_q     <= err_d;
      perr_q    <= perr_d;
      vld_q     <= rd_go;
      last_q    <= release_slot;
    end
  end

  utx_cell_ram #(
    .DW   (DW),
    .DEPTH(DEPTH),
    .AW   (AW)
  ) ram_i (
    .clk  (clk),
    .we   (we),
    .waddr(addr_of(wslot_q, wpos)),
    .wdata(data),
    .re   (rd_go),
    .raddr(addr_of(rslot_q, rbyte_q)),
    .rdata(rd_data)
  );

  assign clav     = clav_q;
  assign cell_rdy = stored_q != '0;
  assign cell_err = err_q;
  assign par_err  = perr_q;
  assign rd_vld   = vld_q;
  assign rd_last  = last_q;

endmodule

// File: rtl/utx_cell_sink.sv
module utx_cell_sink
  import utx_pkg::*;
#(
  parameter int NUM_CH     = UTX_DEF_CH,
  parameter int DW         = UTX_DEF_DW,
  parameter int CELL_BYTES = UTX_DEF_CELL,
  parameter int CELLS      = UTX_DEF_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_mode,
  input  logic [NUM_CH-1:0]    tx_en,
  input  logic [DW-1:0]        tx_data,
  input  logic                 tx_par,
  input  logic                 tx_soc,
  output logic [NUM_CH-1:0]    tx_clav,
  output logic [NUM_CH-1:0]    cell_rdy,
  input  logic [NUM_CH-1:0]    rd_en,
  output logic [NUM_CH*DW-1:0] rd_data,
  output logic [NUM_CH-1:0]    rd_vld,
  output logic [NUM_CH-1:0]    rd_last,
  output logic [NUM_CH-1:0]    cell_err,
  output logic [NUM_CH-1:0]    par_err,
  output logic                 proto_err
);

  localparam int EC_W = $clog2(NUM_CH + 1);

  utx_mode_e mode_q;
  logic      multi, proto_q;
  logic [EC_W-1:0] en_cnt;

  always_comb begin
    en_cnt = '0;
    for (int i = 0; i < NUM_CH; i++) en_cnt = en_cnt + EC_W'(tx_en[i]);
    multi = en_cnt > EC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_CELL;
      proto_q <= 1'b0;
    end else begin
      if (cfg_we) mode_q <= utx_mode_e'(cfg_mode);
      proto_q <= multi;
    end
  end

  assign proto_err = proto_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    utx_chan_ctrl #(
      .DW        (DW),
      .CELL_BYTES(CELL_BYTES),
      .CELLS     (CELLS)
    ) chan_i (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_q),
      .take    (tx_en[c] & ~multi),
      .soc     (tx_soc),
      .data    (tx_data),
      .par     (tx_par),
      .rd_en   (rd_en[c]),
      .clav    (tx_clav[c]),
      .cell_rdy(cell_rdy[c]),
      .cell_err(cell_err[c]),
      .par_err (par_err[c]),
      .rd_data (rd_data[c*DW +: DW]),
      .rd_vld  (rd_vld[c]),
      .rd_last (rd_last[c])
    );
  end

endmodule

// File: rtl/utx_cell_sink_chk.sv
module utx_cell_sink_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] tx_en,
  input logic              proto_err,
  input logic [NUM_CH-1:0] par_err,
  input logic [NUM_CH-1:0] rd_en,
  input logic [NUM_CH-1:0] rd_vld,
  input logic [NUM_CH-1:0] rd_last
);

  AST_PROTO_ON_MULTI: assert property (@(posedge clk) disable iff (rst)
    ($countones(tx_en) > 1) |=> proto_err); // R9

  AST_PROTO_ONLY_MULTI: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past($countones(tx_en) > 1)); // R9

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(par_err) & ~par_err) == '0)); // R7

  AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    ((rd_vld & ~$past(rd_en)) == '0)); // R10

  AST_LAST_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
    ((rd_last & ~rd_vld) == '0)); // R10

endmodule

bind utx_cell_sink utx_cell_sink_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tx_en    (tx_en),
  .proto_err(proto_err),
  .par_err  (par_err),
  .rd_en    (rd_en),
  .rd_vld   (rd_vld),
  .rd_last  (rd_last)
);

// File: tb/utx_cell_sink_tb_top.sv
`timescale 1ns/1ps
module utx_cell_sink_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_mode = 1'b0;
  logic [2:0] tx_en = '0;
  logic [7:0] tx_data = '0;
  logic       tx_par = 1'b0, tx_soc = 1'b0;
  logic [2:0] tx_clav, cell_rdy, rd_vld, rd_last, cell_err, par_err;
  logic [2:0] rd_en = '0;
  logic [23:0] rd_data;
  logic       proto_err;

  int nchk = 0, nfail = 0;
  logic [2:0] snap_err, snap_clav;
  logic       snap_proto, snap_proto_next;
  logic [7:0] q0[$], q1[$], q2[$];
  int         mcnt [3] = '{0, 0, 0};

  always #2.5 clk = ~clk;

  utx_cell_sink dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .tx_en(tx_en), .tx_data(tx_data), .tx_par(tx_par), .tx_soc(tx_soc),
    .tx_clav(tx_clav), .cell_rdy(cell_rdy), .rd_en(rd_en), .rd_data(rd_data),
    .rd_vld(rd_vld), .rd_last(rd_last), .cell_err(cell_err), .par_err(par_err),
    .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int c, input logic [7:0] b);
    case (c)
      0: q0.push_back(b);
      1: q1.push_back(b);
      default: q2.push_back(b);
    endcase
  endtask

  function automatic int qsize(input int c);
    case (c)
      0: return q0.size();
      1: return q1.size();
      default: return q2.size();
    endcase
  endfunction

  // scoreboard monitor: compares each read byte against the expected queue
  initial forever begin
    @(posedge clk);
    #1;
    for (int c = 0; c < 3; c++) begin
      if (rd_vld[c]) begin
        if (qsize(c) == 0) begin
          chk("R10 unexpected byte", 32'(rd_data[c*8 +: 8]), 32'hFFFF);
        end else begin
          logic [7:0] e;
          case (c)
            0: e = q0.pop_front();
            1: e = q1.pop_front();
            default: e = q2.pop_front();
          endcase
          chk("R5 read data", 32'(rd_data[c*8 +: 8]), 32'(e));
          chk("R10 last flag", 32'(rd_last[c]), 32'(mcnt[c] == 52));
          mcnt[c] = (mcnt[c] == 52) ? 0 : mcnt[c] + 1;
        end
      end
    end
  end

  task automatic put_byte(input logic [2:0] en, input logic [7:0] d,
                          input logic soc, input logic bad);
    @(negedge clk);
    tx_en = en; tx_data = d; tx_soc = soc; tx_par = (~^d) ^ bad;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tx_en = '0; tx_soc = 1'b0;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic drain(input int c);
    @(negedge clk); rd_en[c] = 1'b1;
    repeat (53) @(negedge clk);
    rd_en[c] = 1'b0;
    idle(2);
  endtask

  task automatic send_cell(input int ch, input logic [7:0] base, input int gap,
                           input int bad_at, input int multi_at, input bit keep);
    for (int i = 0; i < 53; i++) begin
      if (i == multi_at) begin
        put_byte(3'b011, 8'hEE, 1'b0, 1'b0);
        snap_proto = proto_err;
      end
      put_byte(3'(1 << ch), base + 8'(i), i == 0, i == bad_at);
      if (i == 0) snap_err = cell_err;
      if (i == 10) snap_clav = tx_clav;
      if (i == multi_at) snap_proto_next = proto_err;
      if (keep) push(ch, base + 8'(i));
      if (gap > 0 && (i % 7) == 3) idle(gap);
    end
    idle(1);
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R2 clav low in reset", 32'(tx_clav), 32'h0);
    chk("R10 no cell in reset", 32'(cell_rdy), 32'h0);
    @(negedge clk); rst = 1'b0;
    idle(2);
    chk("R2 clav after reset", 32'(tx_clav), 32'h7);
    chk("R7 par_err clear", 32'(par_err), 32'h0);

    // R2/R11: default cell mode, look-ahead flag drops during second cell
    send_cell(0, 8'h00, 0, -1, -1, 1);
    chk("R10 cell ready", 32'(cell_rdy), 32'h1);
    send_cell(0, 8'h80, 0, -1, -1, 1);
    chk("R11 cell mode default, clav low mid cell", 32'(snap_clav), 32'h6);
    idle(1);
    chk("R2 clav low when full", 32'(tx_clav[0]), 32'h0);

    // R8: cell mode, start with no free slot
    put_byte(3'b001, 8'h55, 1'b1, 1'b0);
    chk("R8 overflow error pulse", 32'(cell_err), 32'h1);
    idle(1);
    chk("R8 error one cycle", 32'(cell_err), 32'h0);

    drain(0);
    drain(0);
    chk("R10 empty after drain", 32'(cell_rdy[0]), 32'h0);
    chk("R2 clav back", 32'(tx_clav[0]), 32'h1);

    // R10: read request with nothing stored
    @(negedge clk); rd_en[0] = 1'b1;
    @(posedge clk); #1;
    chk("R10 rd_en ignored when empty", 32'(rd_vld[0]), 32'h0);
    @(negedge clk); rd_en[0] = 1'b0;

    // R4/R7: paused cell with one bad parity byte
    send_cell(1, 8'h40, 2, 17, -1, 1);
    chk("R7 sticky parity flag", 32'(par_err), 32'h2);
    drain(1);
    chk("R7 flag stays", 32'(par_err), 32'h2);

    // R6: runt cell then full cell, then stray byte
    for (int i = 0; i < 20; i++) put_byte(3'b100, 8'h90 + 8'(i), i == 0, 1'b0);
    send_cell(2, 8'hA0, 0, -1, -1, 1);
    chk("R6 runt error pulse", 32'(snap_err), 32'h4);
    put_byte(3'b100, 8'h11, 1'b0, 1'b0);
    chk("R6 stray byte error", 32'(cell_err), 32'h4);
    idle(1);
    drain(2);
    chk("R6 only full cell kept", 32'(cell_rdy[2]), 32'h0);

    // R9: multi-enable byte inside a live cell
    send_cell(1, 8'h60, 0, -1, 25, 1);
    chk("R9 proto pulse", 32'(snap_proto), 32'h1);
    chk("R9 proto one cycle", 32'(snap_proto_next), 32'h0);
    drain(1);

    // R1: interleaved cells on two channels
    for (int i = 0; i < 53; i++) begin
      put_byte(3'b010, 8'h20 + 8'(i), i == 0, 1'b0); push(1, 8'h20 + 8'(i));
      put_byte(3'b100, 8'hC0 + 8'(i), i == 0, 1'b0); push(2, 8'hC0 + 8'(i));
    end
    idle(1);
    chk("R1 both channels complete", 32'(cell_rdy), 32'h6);
    chk("R1 no errors", 32'(cell_err), 32'h0);
    drain(1);
    drain(2);

    // R3/R8: byte mode
    set_mode(1'b1);
    idle(2);
    send_cell(2, 8'h10, 0, -1, -1, 1);
    send_cell(2, 8'h70, 0, -1, -1, 1);
    chk("R3 clav held mid cell", 32'(snap_clav[2]), 32'h1);
    idle(1);
    chk("R3 clav low when full", 32'(tx_clav[2]), 32'h0);
    put_byte(3'b100, 8'h33, 1'b1, 1'b0);
    chk("R8 byte mode start ignored", 32'(cell_err), 32'h0);
    idle(1);
    drain(2);
    drain(2);
    chk("R4 byte not taken", 32'(cell_rdy[2]), 32'h0);

    idle(2);
    chk("R5 queues empty", 32'(qsize(0) + qsize(1) + qsize(2)), 32'h0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule